// File: doc/BRIEF.md
# Full-Speed Serial Bus Line Receiver

This block sits behind a full-speed differential transceiver and watches the two single-ended data lines with a sample clock running at exactly four times the 12 Mbit/s bit rate. Each sample is classified as one of four line states. The block then measures how many samples each state is held for. The length of each run is turned into a number of bit times. From these it rebuilds the NRZI-decoded serial data and removes the zeros that the transmitter inserted for bit stuffing.

Decoded bits leave one per clock on `bit_data`, qualified by `bit_valid`. Separate one-clock pulses mark the start of a packet, a normal end-of-packet, a bus reset and a bit-stuffing violation. A state that lasts a single sample is treated as noise and has no effect on the decoding. End-of-packet and bus reset are told apart only by how long both lines stay low. The downstream packet layer consumes the bit stream and the markers. It does its own CRC and field handling.

Top module: `usbfs_line_rx`

## Requirements
- R1: The line pair {D+, D-} is decoded as 2'b10 = J, 2'b01 = K, 2'b00 = SE0 and 2'b11 = SE1. J is the idle state.
- R2: From idle, the first change from J to K (K held for at least two samples) raises `pkt_start` for one clock. In that same clock `bit_valid` is high and `bit_data` is 0.
- R3: Inside a packet, every change between J and K yields a 0 bit. Each further bit time spent in the same state yields a 1 bit. A run of N samples lasts floor((N+2)/4) bit times, so a 5-sample run counts as 1 bit time and a 6-sample run counts as 2.
- R4: A 0 bit that follows six consecutive 1 bits is a stuffed bit. It is discarded and raises no `bit_valid`.
- R5: A seventh consecutive 1 bit is still delivered with `bit_valid` high and `bit_data` 1. In that same clock `stuff_err` pulses once.
- R6: An SE0 of 2 to 13 samples that ends a packet gives exactly one `pkt_eop` pulse when the lines leave SE0. No data bit is produced for it.
- R7: An SE0 that lasts 14 samples or longer gives exactly one `bus_reset` pulse and no `pkt_eop`. Any packet in progress is abandoned.
- R8: A line state that lasts one sample is ignored. It does not count as a change and leaves the bit stream unchanged. Time spent idle in J produces no bits. All outputs are low while reset is applied and after it.
- R9: SE1 held for two or more samples abandons the packet without `pkt_eop`. After an end-of-packet, a bus reset or such an abort, the receiver is idle, and the next J-to-K change raises a fresh `pkt_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, four times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_dp | input | 1 | Positive data line level |
| line_dm | input | 1 | Negative data line level |
| bit_valid | output | 1 | One-clock strobe for each decoded data bit |
| bit_data | output | 1 | Decoded data bit, valid while `bit_valid` is high |
| pkt_start | output | 1 | Pulse with the first bit of a packet |
| pkt_eop | output | 1 | Pulse when a short SE0 ends a packet |
| bus_reset | output | 1 | Pulse when SE0 reaches reset length |
| stuff_err | output | 1 | Pulse with a seventh consecutive 1 bit |

## Verification
Two pairs of outputs can fire in the same clock. The stuffing-error flag fires together with the delivery of the offending 1 bit, and the packet-start marker fires together with the first 0 bit. To provoke the stuffing case, K is held for eight bit times right after the opening transition. The bench then checks that eight bits arrive, that the last seven of them are ones, and that exactly one stuffing pulse appears. The start case is judged on every packet: the bench checks that the first bit captured after a start pulse is 0, and that exactly one start pulse is counted per packet.

// File: rtl/usbfs_rx_pkg.sv
package usbfs_rx_pkg;

  // Line state encoding: {positive line, negative line}
  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_K   = 2'b01,
    SYM_J   = 2'b10,
    SYM_SE1 = 2'b11
  } line_sym_e;

  function automatic logic sym_is_diff(input line_sym_e s);
    return (s == SYM_J) || (s == SYM_K);
  endfunction

endpackage

// File: rtl/usbfs_rx_front.sv
module usbfs_rx_front
  import usbfs_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_dp,
  input  logic      line_dm,
  output logic      rst_int_n,
  output line_sym_e sym_o
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_int_n = rst_pipe_q[1];

  // Line synchronizers, reset to the idle J level
  logic [SYNC_STAGES-1:0] dp_q;
  logic [SYNC_STAGES-1:0] dm_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) begin
          dp_q[0] <= 1'b1;
          dm_q[0] <= 1'b0;
        end else begin
          dp_q[0] <= line_dp;
          dm_q[0] <= line_dm;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) begin
          dp_q[g] <= 1'b1;
          dm_q[g] <= 1'b0;
        end else begin
          dp_q[g] <= dp_q[g-1];
          dm_q[g] <= dm_q[g-1];
        end
      end
    end
  end

  assign sym_o = line_sym_e'({dp_q[SYNC_STAGES-1], dm_q[SYNC_STAGES-1]});

endmodule

// File: rtl/usbfs_rx_runlen.sv
module usbfs_rx_runlen
  import usbfs_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  line_sym_e        sym_i,
  output logic             acc_o,      // new state confirmed this sample
  output line_sym_e        new_sym_o,  // state being confirmed
  output line_sym_e        old_sym_o,  // state of the run just ended
  output line_sym_e        run_sym_o,  // confirmed state after this sample
  output logic [CNT_W-1:0] run_idx_o   // sample index inside the run
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_CONF = CNT_W'(2);

  line_sym_e        prev_q, cur_q, cur_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             acc;
  logic             cur_en;

  // A state is confirmed on its second consecutive sample; a lone sample
  // is counted into the ongoing run.
  always_comb begin
    acc    = (sym_i == prev_q) && (prev_q != cur_q);
    cur_en = acc;
    cur_d  = prev_q;
    if (acc)                  cnt_d = CNT_CONF;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= SYM_J;
      cur_q  <= SYM_J;
      cnt_q  <= CNT_W'(1);
    end else begin
      prev_q <= sym_i;
      cnt_q  <= cnt_d;
      if (cur_en) cur_q <= cur_d;
    end
  end

  assign acc_o     = acc;
  assign new_sym_o = prev_q;
  assign old_sym_o = cur_q;
  assign run_sym_o = acc ? prev_q : cur_q;
  assign run_idx_o = cnt_d;

endmodule

// File: rtl/usbfs_rx_decode.sv
module usbfs_rx_decode
  import usbfs_rx_pkg::*;
#(
  parameter int OSR          = 4,
  parameter int CNT_W        = 8,
  parameter int EOP_MAX_BITS = 3,
  parameter int STUFF_RUN    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  line_sym_e        new_sym_i,
  input  line_sym_e        old_sym_i,
  input  line_sym_e        run_sym_i,
  input  logic [CNT_W-1:0] run_idx_i,
  output logic             bit_valid_o,
  output logic             bit_data_o,
  output logic             start_o,
  output logic             eop_o,
  output logic             breset_o,
  output logic             serr_o
);

  // A mid-run bit at index i is confirmed one sample later (index i+1)
  localparam int EMIT_FIRST = OSR + OSR / 2 + 1;
  localparam int EMIT_PHASE = (OSR / 2 + 1) % OSR;
  localparam int RESET_IDX  = EOP_MAX_BITS * OSR + OSR / 2 + 1;
  localparam int ONES_W     = $clog2(STUFF_RUN + 2);
  localparam logic [ONES_W-1:0] ONES_STUFF = ONES_W'(STUFF_RUN);
  localparam logic [ONES_W-1:0] ONES_SAT   = ONES_W'(STUFF_RUN + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX    = '1;

  logic              in_pkt_q, in_pkt_d;
  logic [ONES_W-1:0] ones_q, ones_d;
  logic              bv_q, bv_d, bd_q, bd_d;
  logic              st_q, st_d, eop_q, eop_d, br_q, br_d, se_q, se_d;
  logic              mid_bit;
  logic              at_reset;

  always_comb begin
    mid_bit  = !acc_i && in_pkt_q && sym_is_diff(run_sym_i)
               && (run_idx_i >= CNT_W'(EMIT_FIRST))
               && (run_idx_i != CNT_MAX)
               && ((run_idx_i % CNT_W'(OSR)) == CNT_W'(EMIT_PHASE));
    at_reset = !acc_i && (run_sym_i == SYM_SE0)
               && (run_idx_i == CNT_W'(RESET_IDX));
  end

  always_comb begin
    in_pkt_d = in_pkt_q;
    ones_d   = ones_q;
    bv_d     = 1'b0;
    bd_d     = 1'b0;
    st_d     = 1'b0;
    eop_d    = 1'b0;
    br_d     = 1'b0;
    se_d     = 1'b0;
    if (acc_i) begin
      if (old_sym_i == SYM_SE0) begin
        eop_d    = in_pkt_q;
        in_pkt_d = 1'b0;
        ones_d   = '0;
      end else if (new_sym_i == SYM_SE0) begin
        // wait for the end of SE0 to classify it
        in_pkt_d = in_pkt_q;
      end else if (!sym_is_diff(new_sym_i) || !sym_is_diff(old_sym_i)) begin
        in_pkt_d = 1'b0;
        ones_d   = '0;
      end else if (!in_pkt_q) begin
        if ((old_sym_i == SYM_J) && (new_sym_i == SYM_K)) begin
          st_d     = 1'b1;
          bv_d     = 1'b1;
          in_pkt_d = 1'b1;
          ones_d   = '0;
        end
      end else begin
        bv_d   = (ones_q != ONES_STUFF);
        ones_d = '0;
      end
    end else begin
      if (mid_bit) begin
        bv_d = 1'b1;
        bd_d = 1'b1;
        se_d = (ones_q == ONES_STUFF);
        if (ones_q != ONES_SAT) ones_d = ones_q + 1'b1;
      end
      if (at_reset) begin
        br_d     = 1'b1;
        in_pkt_d = 1'b0;
        ones_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      ones_q   <= '0;
      bv_q     <= 1'b0;
      bd_q     <= 1'b0;
      st_q     <= 1'b0;
      eop_q    <= 1'b0;
      br_q     <= 1'b0;
      se_q     <= 1'b0;
    end else begin
      in_pkt_q <= in_pkt_d;
      ones_q   <= ones_d;
      bv_q     <= bv_d;
      bd_q     <= bd_d;
      st_q     <= st_d;
      eop_q    <= eop_d;
      br_q     <= br_d;
      se_q     <= se_d;
    end
  end

  assign bit_valid_o = bv_q;
  assign bit_data_o  = bd_q;
  assign start_o     = st_q;
  assign eop_o       = eop_q;
  assign breset_o    = br_q;
  assign serr_o      = se_q;

endmodule

// File: rtl/usbfs_line_rx.sv
module usbfs_line_rx
  import usbfs_rx_pkg::*;
#(
  parameter int OSR          = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int CNT_W        = 8,
  parameter int EOP_MAX_BITS = 3,
  parameter int STUFF_RUN    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_dp,
  input  logic line_dm,
  output logic bit_valid,
  output logic bit_data,
  output logic pkt_start,
  output logic pkt_eop,
  output logic bus_reset,
  output logic stuff_err
);

  logic             rst_int_n;
  line_sym_e        sym;
  logic             acc;
  line_sym_e        new_sym, old_sym, run_sym;
  logic [CNT_W-1:0] run_idx;

  usbfs_rx_front #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_dp  (line_dp),
    .line_dm  (line_dm),
    .rst_int_n(rst_int_n),
    .sym_o    (sym)
  );

  usbfs_rx_runlen #(
    .CNT_W(CNT_W)
  ) u_runlen (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sym_i    (sym),
    .acc_o    (acc),
    .new_sym_o(new_sym),
    .old_sym_o(old_sym),
    .run_sym_o(run_sym),
    .run_idx_o(run_idx)
  );

  usbfs_rx_decode #(
    .OSR         (OSR),
    .CNT_W       (CNT_W),
    .EOP_MAX_BITS(EOP_MAX_BITS),
    .STUFF_RUN   (STUFF_RUN)
  ) u_decode (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .acc_i      (acc),
    .new_sym_i  (new_sym),
    .old_sym_i  (old_sym),
    .run_sym_i  (run_sym),
    .run_idx_i  (run_idx),
    .bit_valid_o(bit_valid),
    .bit_data_o (bit_data),
    .start_o    (pkt_start),
    .eop_o      (pkt_eop),
    .breset_o   (bus_reset),
    .serr_o     (stuff_err)
  );

endmodule

// File: rtl/usbfs_line_rx_chk.sv
module usbfs_line_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_valid,
  input logic bit_data,
  input logic pkt_start,
  input logic pkt_eop,
  input logic bus_reset,
  input logic stuff_err
);

  assert_start_zero_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> (bit_valid && !bit_data));

  assert_stuff_on_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> (bit_valid && bit_data));

  assert_eop_no_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_eop |-> !bit_valid);

  assert_markers_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_start, pkt_eop, bus_reset}));

  assert_reset_no_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> !bit_valid);

  assert_idle_after_eop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_eop |=> (!bit_valid && !pkt_eop));

endmodule

bind usbfs_line_rx usbfs_line_rx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_valid(bit_valid),
  .bit_data (bit_data),
  .pkt_start(pkt_start),
  .pkt_eop  (pkt_eop),
  .bus_reset(bus_reset),
  .stuff_err(stuff_err)
);

// File: tb/sim_usbfs_line_rx.sv
module sim_usbfs_line_rx;

  localparam logic [1:0] LJ   = 2'b10;
  localparam logic [1:0] LK   = 2'b01;
  localparam logic [1:0] LSE0 = 2'b00;
  localparam logic [1:0] LSE1 = 2'b11;

  // {jitter[31:30], nbits[29:25], data[24:0]}, data sent LSB first, bit0 = 0
  localparam logic [31:0] VEC [7] = '{
    {2'd0, 5'd8,  25'h0000080},
    {2'd1, 5'd16, 25'h000A5C2},
    {2'd0, 5'd12, 25'h00001FE},
    {2'd2, 5'd20, 25'h00FFFFE},
    {2'd1, 5'd24, 25'h05A3C96},
    {2'd0, 5'd7,  25'h000007E},
    {2'd2, 5'd16, 25'h0000F0E}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b1;
  logic dm = 1'b0;
  logic bit_valid, bit_data, pkt_start, pkt_eop, bus_reset, stuff_err;

  int n_chk = 0;
  int n_fail = 0;
  int ncap = 0;
  int n_start = 0, n_eop = 0, n_rst = 0, n_serr = 0;
  logic [31:0] capw = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usbfs_line_rx u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_dp  (dp),
    .line_dm  (dm),
    .bit_valid(bit_valid),
    .bit_data (bit_data),
    .pkt_start(pkt_start),
    .pkt_eop  (pkt_eop),
    .bus_reset(bus_reset),
    .stuff_err(stuff_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid) begin
        if (ncap < 32) capw[ncap] = bit_data;
        ncap = ncap + 1;
      end
      if (pkt_start) n_start = n_start + 1;
      if (pkt_eop)   n_eop   = n_eop + 1;
      if (bus_reset) n_rst   = n_rst + 1;
      if (stuff_err) n_serr  = n_serr + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic line(input logic [1:0] s, input int n);
    repeat (n) begin
      @(negedge clk);
      dp = s[1];
      dm = s[0];
    end
  endtask

  task automatic clear_obs();
    @(posedge clk);
    #1;
    ncap = 0; capw = '0;
    n_start = 0; n_eop = 0; n_rst = 0; n_serr = 0;
  endtask

  task automatic send_packet(input logic [24:0] d, input int n, input int jit);
    bit lvl_j;
    bit alt;
    int ones;
    int w;
    lvl_j = 1'b1; alt = 1'b0; ones = 0;
    line(LJ, 8);
    for (int i = 0; i < n; i++) begin
      if (!d[i]) begin lvl_j = !lvl_j; ones = 0; end
      else ones = ones + 1;
      w = (jit == 0) ? 4 : ((jit == 1) ^ alt) ? 3 : 5;
      alt = !alt;
      line(lvl_j ? LJ : LK, w);
      if (ones == 6) begin
        lvl_j = !lvl_j; ones = 0;
        w = (jit == 0) ? 4 : ((jit == 1) ^ alt) ? 3 : 5;
        alt = !alt;
        line(lvl_j ? LJ : LK, w);
      end
    end
    line(LSE0, 8);
    line(LJ, 10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // reset state, R8
    repeat (4) @(negedge clk);
    check("R8 reset bit_valid", int'(bit_valid), 0);
    check("R8 reset markers", int'({pkt_start, pkt_eop, bus_reset, stuff_err}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    line(LJ, 40);
    check("R8 idle J gives no bits", ncap, 0);

    // Table of packets: R2, R3, R4, R6
    for (int v = 0; v < 7; v++) begin
      logic [24:0] d;
      logic [31:0] mask;
      int n;
      int jit;
      d = VEC[v][24:0];
      n = int'(VEC[v][29:25]);
      jit = int'(VEC[v][31:30]);
      mask = (32'd1 << n) - 32'd1;
      clear_obs();
      send_packet(d, n, jit);
      check("R4 bit count after destuffing", ncap, n);
      check("R3 decoded stream", int'(capw & mask), int'({7'd0, d} & mask));
      check("R2 one start per packet", n_start, 1);
      check("R2 first bit is zero", int'(capw[0]), 0);
      check("R6 one eop per packet", n_eop, 1);
      check("R5 no stuff error on legal stream", n_serr, 0);
    end

    // R3 run rounding: K5 -> 1 bit, J6 -> 2 bits, K4 -> 1 bit
    clear_obs();
    line(LJ, 8); line(LK, 5); line(LJ, 6); line(LK, 4); line(LSE0, 8); line(LJ, 10);
    check("R3 rounding bit count", ncap, 4);
    check("R3 rounding stream", int'(capw[3:0]), 4'b0100);

    // R5 stuffing violation: 0 then seven ones
    clear_obs();
    line(LJ, 8); line(LK, 32); line(LSE0, 8); line(LJ, 10);
    check("R5 bits delivered", ncap, 8);
    check("R5 stream", int'(capw[7:0]), 8'hFE);
    check("R5 stuff error pulses", n_serr, 1);

    // R6 boundary: 13 samples of SE0 is end-of-packet
    clear_obs();
    line(LJ, 8); line(LK, 4); line(LJ, 4); line(LSE0, 13); line(LJ, 10);
    check("R6 SE0 13 eop", n_eop, 1);
    check("R6 SE0 13 no reset", n_rst, 0);
    check("R6 SE0 13 bits", ncap, 2);

    // R7 boundary: 14 samples of SE0 is a bus reset
    clear_obs();
    line(LJ, 8); line(LK, 4); line(LJ, 4); line(LSE0, 14); line(LJ, 10);
    check("R7 SE0 14 reset", n_rst, 1);
    check("R7 SE0 14 no eop", n_eop, 0);

    // R7 long reset, then R9 fresh packet
    clear_obs();
    line(LSE0, 60); line(LJ, 10);
    check("R7 long SE0 one reset", n_rst, 1);
    check("R7 long SE0 no eop", n_eop, 0);
    clear_obs();
    send_packet(25'h80, 8, 0);
    check("R9 start after reset", n_start, 1);
    check("R9 stream after reset", int'(capw[7:0]), 8'h80);

    // R8 glitch while idle
    clear_obs();
    line(LJ, 8); line(LK, 1); line(LJ, 12);
    check("R8 idle glitch no start", n_start, 0);
    check("R8 idle glitch no bits", ncap, 0);

    // R8 glitch inside a run: J run of 12 samples with one K sample
    clear_obs();
    line(LJ, 8); line(LK, 4); line(LJ, 5); line(LK, 1); line(LJ, 6);
    line(LK, 4); line(LSE0, 8); line(LJ, 10);
    check("R8 glitch bit count", ncap, 5);
    check("R8 glitch stream", int'(capw[4:0]), 5'b01100);

    // R9 SE1 abort, then R1 normal packet restarts
    clear_obs();
    line(LJ, 8); line(LK, 4); line(LJ, 4); line(LSE1, 8); line(LJ, 10);
    check("R9 SE1 no eop", n_eop, 0);
    check("R9 SE1 bits before abort", ncap, 2);
    clear_obs();
    send_packet(25'hA5C2, 16, 0);
    check("R9 start after SE1", n_start, 1);
    check("R1 stream after SE1", int'(capw[15:0]), 16'hA5C2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule